// File: doc/BRIEF.md
# Programmable Inter-Frame Gap Timer

This block holds off the Ethernet transmit datapath for the idle time required between frames. When the datapath signals that the last byte of a frame has gone out, the block drops its ready output and counts a gap measured in byte times. It raises ready again once the gap has elapsed, and the datapath may then begin the next frame. The block runs from a single 125 MHz clock at all three link speeds. A byte time is one clock at 1000 Mb/s, ten clocks at 100 Mb/s and one hundred clocks at 10 Mb/s.

The gap length comes from a 3-bit code. The shortest gap is 96 bit times, which is 12 byte times. Five code values lengthen it by 0, 1, 2, 3 or 6 byte times, so the longest gap is 144 bit times. The mapping is not monotonic in the code value. The same code has the same meaning at every link speed. The remaining three code values are reserved. The block flags them and uses the shortest gap in their place. The code and the speed are captured only at the end of a frame, so a change made while a gap is running takes effect from the next gap.

Top module: `ifg_timer`

## Requirements
- R1: After reset, `tx_ready` is 1 and `code_err` is 0.
- R2: A `frame_end` pulse sampled at a clock edge makes `tx_ready` 0 after that edge.
- R3: At 1000 Mb/s the gap length is set by `gap_code`. 3'b011 gives 12 byte times, 3'b101 gives 13, 3'b111 gives 14, 3'b001 gives 15 and 3'b010 gives 18. `tx_ready` stays low for exactly that many clock cycles after the edge that sampled `frame_end`.
- R4: One byte time lasts 1 cycle when `speed_sel` is 2'b10 or 2'b11, 10 cycles when it is 2'b01, and 100 cycles when it is 2'b00. The low time of `tx_ready` is the byte count from R3 multiplied by this figure.
- R5: The reserved codes 3'b000, 3'b100 and 3'b110 set `code_err` to 1 after the sampling edge and give a 12-byte-time gap. A valid code sets `code_err` to 0.
- R6: `code_err` changes only at an edge that samples `frame_end`.
- R7: `gap_code` and `speed_sel` are used only at the edge that samples `frame_end`. Changing them during a gap does not alter that gap, and the new values apply to the next gap.
- R8: A `frame_end` that arrives while `tx_ready` is 0 restarts the full gap from the edge that samples it.
- R9: When `frame_end` falls in the same cycle as the final byte-time tick of a gap, `tx_ready` stays 0 and a full new gap starts.
- R10: While `frame_end` stays low, a high `tx_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_sel | input | 2 | Link speed: 00 = 10 Mb/s, 01 = 100 Mb/s, 10 or 11 = 1000 Mb/s |
| gap_code | input | 3 | Gap length code |
| frame_end | input | 1 | One-cycle pulse on the last byte of a frame |
| tx_ready | output | 1 | High when the next frame may start |
| code_err | output | 1 | High when the code captured at the last frame end was reserved |

## Verification
Two events can fall in the same cycle: the reload caused by a new frame end, and the final byte-time tick that would raise ready. To force this, the bench starts a 12-cycle gap at 1000 Mb/s, waits eleven edges, and then drives `frame_end` so that the twelfth edge samples it. That edge must leave ready low, and a full 12-cycle gap must then follow. A second case restarts a gap partway through at 100 Mb/s. The bench measures the total low time from that restart, so any credit carried over from the first gap shows up as a short count.

// File: rtl/ifg_pkg.sv
package ifg_pkg;

   typedef enum logic [1:0] {
      SPD_10M    = 2'b00,
      SPD_100M   = 2'b01,
      SPD_1G     = 2'b10,
      SPD_1G_ALT = 2'b11
   } spd_e;

   // Largest extension any valid code adds, in byte times.
   localparam int unsigned EXT_MAX_BYTES = 6;

   // Extra byte times a gap code adds to the base gap.
   function automatic int unsigned ext_bytes(input logic [2:0] c);
      case (c)
         3'b101:  return 1;
         3'b111:  return 2;
         3'b001:  return 3;
         3'b010:  return 6;
         default: return 0;
      endcase
   endfunction

   function automatic logic code_ok(input logic [2:0] c);
      return (c == 3'b011) || (c == 3'b101) || (c == 3'b111) ||
             (c == 3'b001) || (c == 3'b010);
   endfunction

endpackage

// File: rtl/ifg_code_decode.sv
module ifg_code_decode
   import ifg_pkg::*;
#(
   parameter int unsigned BASE_BYTES = 12,
   parameter int unsigned CNT_W      = 5
) (
   input  logic [2:0]       code,
   output logic [CNT_W-1:0] load_val,
   output logic             reserved
);

   logic [CNT_W-1:0] len_tbl [8];
   logic [7:0]       rsv_tbl;

   // One table entry per code value, built at elaboration.
   for (genvar g = 0; g < 8; g++) begin : g_ent
      localparam logic [2:0] C = 3'(g);
      assign len_tbl[g] = CNT_W'(BASE_BYTES + ext_bytes(C));
      assign rsv_tbl[g] = ~code_ok(C);
   end

   assign load_val = len_tbl[code];
   assign reserved = rsv_tbl[code];

endmodule

// File: rtl/ifg_byte_tick.sv
module ifg_byte_tick
   import ifg_pkg::*;
#(
   parameter int unsigned DIV_100 = 10,
   parameter int unsigned DIV_10  = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   input  spd_e spd,
   output logic tick
);

   localparam int unsigned DIV_W = (DIV_10 > 1) ? $clog2(DIV_10) : 1;

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] lim_m1;

   always_comb begin
      case (spd)
         SPD_10M:  lim_m1 = DIV_W'(DIV_10 - 1);
         SPD_100M: lim_m1 = DIV_W'(DIV_100 - 1);
         default:  lim_m1 = '0;
      endcase
   end

   assign tick = run & (div_q == lim_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
      end else if (clear || tick || !run) begin
         div_q <= '0;
      end else begin
         div_q <= div_q + DIV_W'(1);
      end
   end

endmodule

// File: rtl/ifg_gap_counter.sv
module ifg_gap_counter #(
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   output logic             ready
);

   logic [CNT_W-1:0] cnt_q;
   logic             rdy_q;

   // A start takes priority over the final tick of a running gap.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         rdy_q <= 1'b1;
      end else if (start) begin
         cnt_q <= load_val;
         rdy_q <= 1'b0;
      end else if (!rdy_q && tick) begin
         cnt_q <= cnt_q - CNT_W'(1);
         if (cnt_q == CNT_W'(1)) begin
            rdy_q <= 1'b1;
         end
      end
   end

   assign ready = rdy_q;

endmodule

// File: rtl/ifg_timer.sv
module ifg_timer
   import ifg_pkg::*;
#(
   parameter int unsigned DIV_100    = 10,
   parameter int unsigned DIV_10     = 100,
   parameter int unsigned BASE_BYTES = 12
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] speed_sel,
   input  logic [2:0] gap_code,
   input  logic       frame_end,
   output logic       tx_ready,
   output logic       code_err
);

   localparam int unsigned CNT_W = $clog2(BASE_BYTES + EXT_MAX_BYTES + 1);

   if (DIV_100 < 1 || DIV_10 < DIV_100) begin : g_bad_div
      $error("ifg_timer: dividers must satisfy 1 <= DIV_100 <= DIV_10");
   end
   if (BASE_BYTES < 1) begin : g_bad_base
      $error("ifg_timer: BASE_BYTES must be at least 1");
   end

   spd_e             spd_q;
   logic             err_q;
   logic [CNT_W-1:0] load_val;
   logic             rsv;
   logic             tick;
   logic             ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         spd_q <= SPD_1G;
         err_q <= 1'b0;
      end else if (frame_end) begin
         spd_q <= spd_e'(speed_sel);
         err_q <= rsv;
      end
   end

   ifg_code_decode #(
      .BASE_BYTES(BASE_BYTES),
      .CNT_W     (CNT_W)
   ) u_dec (
      .code    (gap_code),
      .load_val(load_val),
      .reserved(rsv)
   );

   ifg_byte_tick #(
      .DIV_100(DIV_100),
      .DIV_10 (DIV_10)
   ) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .clear(frame_end),
      .run  (~ready),
      .spd  (spd_q),
      .tick (tick)
   );

   ifg_gap_counter #(
      .CNT_W(CNT_W)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (frame_end),
      .load_val(load_val),
      .tick    (tick),
      .ready   (ready)
   );

   assign tx_ready = ready;
   assign code_err = err_q;

endmodule

// File: rtl/ifg_timer_chk.sv
module ifg_timer_chk
   import ifg_pkg::*;
#(
   parameter int unsigned DIV_10     = 100,
   parameter int unsigned BASE_BYTES = 12
) (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] gap_code,
   input logic       frame_end,
   input logic       tx_ready,
   input logic       code_err
);

   localparam int unsigned MAX_GAP = (BASE_BYTES + EXT_MAX_BYTES) * DIV_10;
   localparam int unsigned RUN_W   = $clog2(MAX_GAP + 2) + 1;

   logic             rsv_now;
   logic [RUN_W-1:0] low_run;

   assign rsv_now = (gap_code == 3'b000) || (gap_code == 3'b100) ||
                    (gap_code == 3'b110);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_run <= '0;
      end else if (frame_end) begin
         low_run <= '0;
      end else if (!tx_ready && low_run < RUN_W'(MAX_GAP + 1)) begin
         low_run <= low_run + RUN_W'(1);
      end
   end

   AST_EOF_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> !tx_ready); // R2

   AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      low_run <= RUN_W'(MAX_GAP)); // R3

   AST_ERR_ON_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> (code_err == $past(rsv_now))); // R5

   AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_end |=> $stable(code_err)); // R6

   AST_NO_RISE_ON_EOF: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_ready) |-> !$past(frame_end)); // R9

   AST_READY_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ready && !frame_end) |=> tx_ready); // R10

endmodule

bind ifg_timer ifg_timer_chk #(
   .DIV_10    (DIV_10),
   .BASE_BYTES(BASE_BYTES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .gap_code (gap_code),
   .frame_end(frame_end),
   .tx_ready (tx_ready),
   .code_err (code_err)
);

// File: tb/ifg_timer_test.sv
`timescale 1ns/1ps
module ifg_timer_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] speed_sel = 2'b10;
   logic [2:0] gap_code = 3'b011;
   logic       frame_end = 1'b0;
   logic       tx_ready;
   logic       code_err;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ifg_timer uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .speed_sel(speed_sel),
      .gap_code (gap_code),
      .frame_end(frame_end),
      .tx_ready (tx_ready),
      .code_err (code_err)
   );

   typedef struct packed {
      logic [1:0]  spd;
      logic [2:0]  code;
      logic        err;
      logic [15:0] cyc;
   } vec_t;

   localparam int NVEC = 14;
   localparam vec_t VEC [NVEC] = '{
      '{2'b10, 3'b011, 1'b0, 16'd12},
      '{2'b10, 3'b101, 1'b0, 16'd13},
      '{2'b10, 3'b111, 1'b0, 16'd14},
      '{2'b10, 3'b001, 1'b0, 16'd15},
      '{2'b10, 3'b010, 1'b0, 16'd18},
      '{2'b10, 3'b000, 1'b1, 16'd12},
      '{2'b10, 3'b100, 1'b1, 16'd12},
      '{2'b10, 3'b110, 1'b1, 16'd12},
      '{2'b11, 3'b101, 1'b0, 16'd13},
      '{2'b01, 3'b011, 1'b0, 16'd120},
      '{2'b01, 3'b010, 1'b0, 16'd180},
      '{2'b01, 3'b110, 1'b1, 16'd120},
      '{2'b00, 3'b111, 1'b0, 16'd1400},
      '{2'b00, 3'b011, 1'b0, 16'd1200}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Drive one frame_end pulse; returns just after the sampling edge.
   task automatic pulse();
      @(negedge clk);
      frame_end = 1'b1;
      @(posedge clk);
      #1 frame_end = 1'b0;
   endtask

   // Count edges until tx_ready rises.
   task automatic measure(input int exp, input string req);
      int n = 0;
      while (!tx_ready && n < 4000) begin
         @(posedge clk);
         #1 n++;
      end
      check(n == exp, req, n, exp);
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check(tx_ready == 1'b1, "R1 ready", tx_ready, 1);
      check(code_err == 1'b0, "R1 err", code_err, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R10: idle ready holds
      repeat (20) @(posedge clk);
      #1 check(tx_ready == 1'b1, "R10 idle", tx_ready, 1);

      // Vector walk: R3, R4, R5
      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         speed_sel = VEC[i].spd;
         gap_code  = VEC[i].code;
         pulse();
         check(tx_ready == 1'b0, "R2 drop", tx_ready, 0);
         check(code_err == VEC[i].err, "R5 err flag", code_err, VEC[i].err);
         measure(int'(VEC[i].cyc), "R3/R4 gap length");
      end

      // R6/R7: mid-gap change has no effect on current gap or flag
      @(negedge clk);
      speed_sel = 2'b01;
      gap_code  = 3'b011;
      pulse();
      repeat (5) @(posedge clk);
      @(negedge clk);
      speed_sel = 2'b00;
      gap_code  = 3'b100;
      @(posedge clk);
      #1 check(code_err == 1'b0, "R6 flag held", code_err, 0);
      measure(120 - 6, "R7 current gap");
      check(code_err == 1'b0, "R6 flag after gap", code_err, 0);
      pulse();
      check(code_err == 1'b1, "R7 new code flag", code_err, 1);
      measure(1200, "R7 next gap");

      // R8: restart mid-gap
      @(negedge clk);
      speed_sel = 2'b01;
      gap_code  = 3'b011;
      pulse();
      repeat (50) @(posedge clk);
      pulse();
      check(tx_ready == 1'b0, "R8 low", tx_ready, 0);
      measure(120, "R8 restart");

      // R9: frame_end on the final tick edge
      @(negedge clk);
      speed_sel = 2'b10;
      gap_code  = 3'b011;
      pulse();
      repeat (11) @(posedge clk);
      pulse();
      check(tx_ready == 1'b0, "R9 collision", tx_ready, 0);
      measure(12, "R9 full regap");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule